// File: doc/BRIEF.md
# Marker-Aligned Lane Deskew

This block sits on the receive side of a wide parallel path that crosses an on-package interconnect. Each of its lanes delivers one data word per clock together with a marker flag. Because the lanes cross the interconnect separately, words that were launched in the same cycle can arrive up to three cycles apart. The block finds, within each group of lanes that form one link, the cycle in which every lane sees its marker. It then delays the early lanes so that their markers, and all data after them, leave together with the latest lane.

Lanes come in octets of eight, and no deskew group crosses an octet boundary. A per-octet width code sets how each octet is split into groups, and each octet has its own code. A new code takes effect only on a load pulse, and alignment starts again from scratch at that point. The sender places a marker on every lane every 16 cycles. The block reruns its measurement on every marker round, so a change of skew is picked up without intervention. The stream has no back-pressure: every lane takes and gives one word on every clock, and there is no valid or ready handshake. The marker flag travels with its word so that downstream logic can strip it.

Top module: `lane_deskew_aligner`

## Requirements
- R1: While reset is low, and after it, `out_data`, `out_mark`, `bundle_aligned` and `skew_err` are zero and every octet is in width-1 mode (code 00). Until the first `topo_load`, markers have no effect on `bundle_aligned` or `skew_err`.
- R2: The width code of octet o sits at `topo_code[2o+1:2o]`: 00 is width 1, 01 is width 2, 10 is width 4 and 11 is width 8 (also used for a 16-lane link). Group numbers are octet*4 plus a local index. Width 2 uses local indices 0..3 for lane pairs {0,1},{2,3},{4,5},{6,7}. Width 4 uses 0 for lanes 0..3 and 2 for lanes 4..7. Width 8 uses 0 for all eight lanes. `bundle_aligned[g]` is never high for a group number the current codes do not use.
- R3: Once a group is aligned, every lane of that group outputs, one cycle after input, the word that the latest-arriving lane of the group received on that cycle.
- R4: Skew of 0 to 3 cycles between lanes of a group is fully removed.
- R5: Lanes of a width-1 octet pass through with exactly one register of latency and no added delay.
- R6: Delays are measured again on every marker round, so a new static skew pattern is removed after the following round.
- R7: If some lanes of a group see a marker and the rest do not within 4 cycles, `skew_err` is high for exactly one cycle for that round, and the lane delays keep their previous values.
- R8: `bundle_aligned[g]` is set by a complete marker round and cleared by a failed round, by reset or by `topo_load`.
- R9: `out_mark` of each lane is delayed exactly as its data, so output markers of an aligned group appear in the same cycle.
- R10: A `topo_load` pulse applies `topo_code`, sets all lane delays to zero and clears `bundle_aligned` in the next cycle.
- R11: The two octets are aligned independently; groups in one octet do not affect the delays of the other octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| topo_load | input | 1 | Pulse: apply `topo_code` and restart alignment |
| topo_code | input | 2*NUM_OCTETS | Per-octet width code (R2) |
| in_data | input | NUM_OCTETS*8*LANE_W | Lane words, lane l at bits l*LANE_W upward |
| in_mark | input | NUM_OCTETS*8 | Marker flag per lane |
| out_data | output | NUM_OCTETS*8*LANE_W | Aligned lane words |
| out_mark | output | NUM_OCTETS*8 | Marker flags delayed with their words |
| bundle_aligned | output | NUM_OCTETS*4 | Per-group aligned status |
| skew_err | output | 1 | One-cycle pulse on a failed marker round |

## Verification
The embedded properties check four things on every cycle. A lane with zero delay forwards its previous input. A group is never marked aligned while it reports an error. Aligned status rises only after a completed measurement window. Unused group numbers and the cycle after a reload never show aligned status. Whether the early lanes are held back by the right amount cannot be seen from any single cycle. The directed scenarios show it by comparing every output lane with a model of the latest lane's data. They cover several skew patterns and width mixes, a skew change between rounds, a lane that loses its marker, and the two cases of a bypassed octet and reset in mid-stream.

// File: rtl/lane_dsk_pkg.sv
package lane_dsk_pkg;
  localparam int OCT_LANES    = 8;
  localparam int BUND_PER_OCT = 4;

  typedef enum logic [1:0] {
    TOPO_X1 = 2'b00,
    TOPO_X2 = 2'b01,
    TOPO_X4 = 2'b10,
    TOPO_X8 = 2'b11
  } topo_e;

  // local group index inside an octet, from the lane-pair index (lane/2)
  function automatic logic [1:0] local_bundle(topo_e t, logic [1:0] pair_idx);
    case (t)
      TOPO_X2: return pair_idx;
      TOPO_X4: return {pair_idx[1], 1'b0};
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dsk_lane_delay.sv
module dsk_lane_delay #(
  parameter int LANE_W   = 8,
  parameter int MAX_SKEW = 3,
  localparam int DLY_W   = $clog2(MAX_SKEW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [DLY_W-1:0]  load_dly,
  input  logic [LANE_W-1:0] in_data,
  input  logic              in_mark,
  output logic [LANE_W-1:0] out_data,
  output logic              out_mark
);
  typedef logic [LANE_W:0] word_t;

  word_t            hist_q [MAX_SKEW];
  word_t            in_w, sel_w, out_q;
  logic [DLY_W-1:0] dly_q;

  assign in_w = {in_mark, in_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SKEW; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= in_w;
      for (int i = 1; i < MAX_SKEW; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  always_comb begin
    sel_w = in_w;
    for (int i = 0; i < MAX_SKEW; i++)
      if (int'(dly_q) == i + 1) sel_w = hist_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      out_q <= '0;
    end else begin
      out_q <= sel_w;
      if (clear)     dly_q <= '0;
      else if (load) dly_q <= load_dly;
    end
  end

  assign out_mark = out_q[LANE_W];
  assign out_data = out_q[LANE_W-1:0];

  // R3 R5
  zero_dly_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q == '0) |=> (out_q == $past(in_w)));
endmodule

// File: rtl/dsk_bundle_ctl.sv
module dsk_bundle_ctl #(
  parameter int NUM_LANES = 16,
  parameter int MAX_SKEW  = 3,
  localparam int CNT_W    = $clog2(MAX_SKEW + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic [NUM_LANES-1:0]       member,
  input  logic [NUM_LANES-1:0]       mark,
  output logic                       done,
  output logic [NUM_LANES*CNT_W-1:0] new_dly,
  output logic                       err_q,
  output logic                       aligned_q
);
  logic                       open_q;
  logic [CNT_W-1:0]           cnt_q, cur;
  logic [NUM_LANES-1:0]       seen_q, hit, arrive, seen_nx;
  logic [NUM_LANES*CNT_W-1:0] off_q;
  logic                       all_in, timeout;

  always_comb begin
    hit     = mark & member;
    arrive  = open_q ? (hit & ~seen_q) : hit;
    seen_nx = (open_q ? seen_q : '0) | arrive;
    cur     = open_q ? cnt_q : '0;
    all_in  = (member != '0) && ((seen_nx & member) == member);
    done    = all_in && (arrive != '0);
    timeout = open_q && !all_in && (cnt_q == CNT_W'(MAX_SKEW));
    for (int l = 0; l < NUM_LANES; l++)
      new_dly[l*CNT_W +: CNT_W] = arrive[l] ? '0 : cur - off_q[l*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0; cnt_q <= '0; seen_q <= '0; off_q <= '0;
      err_q  <= 1'b0; aligned_q <= 1'b0;
    end else if (restart) begin
      open_q <= 1'b0; cnt_q <= '0; seen_q <= '0; off_q <= '0;
      err_q  <= 1'b0; aligned_q <= 1'b0;
    end else begin
      err_q <= timeout;
      if (done) begin
        open_q    <= 1'b0;
        aligned_q <= 1'b1;
      end else if (timeout) begin
        open_q    <= 1'b0;
        aligned_q <= 1'b0;
      end else if (open_q || (arrive != '0)) begin
        open_q <= 1'b1;
        cnt_q  <= cur + CNT_W'(1);
        seen_q <= seen_nx;
        for (int l = 0; l < NUM_LANES; l++)
          if (arrive[l]) off_q[l*CNT_W +: CNT_W] <= cur;
      end
    end
  end

  // R7
  err_drops_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !aligned_q);
  // R8
  aligned_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_q) |-> $past(done));
endmodule

// File: rtl/lane_deskew_aligner.sv
module lane_deskew_aligner
  import lane_dsk_pkg::*;
#(
  parameter int NUM_OCTETS = 2,
  parameter int LANE_W     = 8,
  parameter int MAX_SKEW   = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                topo_load,
  input  logic [2*NUM_OCTETS-1:0]             topo_code,
  input  logic [NUM_OCTETS*OCT_LANES*LANE_W-1:0] in_data,
  input  logic [NUM_OCTETS*OCT_LANES-1:0]     in_mark,
  output logic [NUM_OCTETS*OCT_LANES*LANE_W-1:0] out_data,
  output logic [NUM_OCTETS*OCT_LANES-1:0]     out_mark,
  output logic [NUM_OCTETS*BUND_PER_OCT-1:0]  bundle_aligned,
  output logic                                skew_err
);
  localparam int NUM_LANES   = NUM_OCTETS * OCT_LANES;
  localparam int NUM_BUNDLES = NUM_OCTETS * BUND_PER_OCT;
  localparam int BID_W       = $clog2(NUM_BUNDLES);
  localparam int DLY_W       = $clog2(MAX_SKEW + 1);

  topo_e                      topo_q [NUM_OCTETS];
  logic [NUM_LANES-1:0]       lane_inb;
  logic [BID_W-1:0]           lane_bid [NUM_LANES];
  logic [NUM_BUNDLES-1:0]     b_done, b_err, b_used;
  logic [NUM_LANES*DLY_W-1:0] b_dly [NUM_BUNDLES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NUM_OCTETS; o++) topo_q[o] <= TOPO_X1;
    end else if (topo_load) begin
      for (int o = 0; o < NUM_OCTETS; o++) topo_q[o] <= topo_e'(topo_code[2*o +: 2]);
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_map
    localparam int OCT = l / OCT_LANES;
    localparam logic [1:0] PAIR = 2'((l % OCT_LANES) / 2);
    assign lane_inb[l] = (topo_q[OCT] != TOPO_X1);
    assign lane_bid[l] = BID_W'(OCT * BUND_PER_OCT) + BID_W'(local_bundle(topo_q[OCT], PAIR));
  end

  for (genvar b = 0; b < NUM_BUNDLES; b++) begin : g_bund
    logic [NUM_LANES-1:0] mem_v;
    always_comb
      for (int l = 0; l < NUM_LANES; l++)
        mem_v[l] = lane_inb[l] && (lane_bid[l] == BID_W'(b));
    assign b_used[b] = |mem_v;

    dsk_bundle_ctl #(.NUM_LANES(NUM_LANES), .MAX_SKEW(MAX_SKEW)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (topo_load),
      .member    (mem_v),
      .mark      (in_mark),
      .done      (b_done[b]),
      .new_dly   (b_dly[b]),
      .err_q     (b_err[b]),
      .aligned_q (bundle_aligned[b])
    );
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic             upd;
    logic [DLY_W-1:0] ldly;
    always_comb begin
      upd  = lane_inb[l] && b_done[lane_bid[l]];
      ldly = b_dly[lane_bid[l]][l*DLY_W +: DLY_W];
    end

    dsk_lane_delay #(.LANE_W(LANE_W), .MAX_SKEW(MAX_SKEW)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (topo_load),
      .load     (upd),
      .load_dly (ldly),
      .in_data  (in_data[l*LANE_W +: LANE_W]),
      .in_mark  (in_mark[l]),
      .out_data (out_data[l*LANE_W +: LANE_W]),
      .out_mark (out_mark[l])
    );
  end

  assign skew_err = |b_err;

  // R2
  unused_bundle_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle_aligned & ~b_used) == '0);
  // R10
  reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    topo_load |=> (bundle_aligned == '0));
endmodule

// File: tb/lane_deskew_aligner_tb_top.sv
module lane_deskew_aligner_tb_top;
  localparam int NO = 2;
  localparam int NL = 16;
  localparam int W  = 8;
  localparam int NB = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            topo_load = 1'b0;
  logic [2*NO-1:0] topo_code = '0;
  logic [NL*W-1:0] in_data = '0;
  logic [NL-1:0]   in_mark = '0;
  logic [NL*W-1:0] out_data;
  logic [NL-1:0]   out_mark;
  logic [NB-1:0]   bundle_aligned;
  logic            skew_err;

  always #4 clk = ~clk;

  lane_deskew_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .topo_load(topo_load), .topo_code(topo_code),
    .in_data(in_data), .in_mark(in_mark), .out_data(out_data), .out_mark(out_mark),
    .bundle_aligned(bundle_aligned), .skew_err(skew_err)
  );

  int cyc = 64;
  int skew [NL];
  bit men  [NL];
  int mode [NO];
  int n_chk = 0;
  int n_err = 0;

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int grp_of(int l);
    int o = l / 8;
    int p = l % 8;
    case (mode[o])
      0:       return -1;
      1:       return o * 4 + p / 2;
      2:       return o * 4 + (p / 4) * 2;
      default: return o * 4;
    endcase
  endfunction

  function automatic int grp_max(int g);
    int m = 0;
    for (int l = 0; l < NL; l++) if (grp_of(l) == g && skew[l] > m) m = skew[l];
    return m;
  endfunction

  task automatic apply();
    for (int l = 0; l < NL; l++) begin
      int v = cyc - skew[l];
      in_data[l*W +: W] = W'(v);
      in_mark[l] = men[l] && (v % 16 == 0);
    end
  endtask

  task automatic check_lanes(string req);
    for (int l = 0; l < NL; l++) begin
      int g = grp_of(l);
      int e = (g < 0) ? cyc - skew[l] : cyc - grp_max(g);
      check(req, $sformatf("lane %0d data", l), out_data[l*W +: W], e & 255);
      check("R9", $sformatf("lane %0d mark", l), out_mark[l], (men[l] && (e % 16 == 0)) ? 1 : 0);
    end
  endtask

  task automatic adv(int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      apply();
    end
  endtask

  task automatic adv_chk(int n, string req, logic [NB-1:0] exp_al);
    repeat (n) begin
      @(negedge clk);
      check_lanes(req);
      check(req, "bundle_aligned", bundle_aligned, exp_al);
      check(req, "skew_err", skew_err, 0);
      cyc++;
      apply();
    end
  endtask

  task automatic goto_phase(int ph);
    while (cyc % 16 != ph) adv(1);
  endtask

  task automatic set_skews(int s0, int s1, int s2, int s3);
    for (int l = 0; l < NL; l++) begin
      case (l % 4)
        0: skew[l] = (s0 + l / 4) % 4;
        1: skew[l] = (s1 + l / 4) % 4;
        2: skew[l] = (s2 + l / 4) % 4;
        default: skew[l] = (s3 + l / 4) % 4;
      endcase
    end
  endtask

  task automatic load(int c0, int c1);
    goto_phase(8);
    @(negedge clk);
    topo_code = {2'(c1), 2'(c0)};
    topo_load = 1'b1;
    cyc++;
    apply();
    @(negedge clk);
    topo_load = 1'b0;
    mode[0] = c0;
    mode[1] = c1;
    // R10: status cleared in the cycle after the load pulse
    check("R10", "bundle_aligned after load", bundle_aligned, 0);
    cyc++;
    apply();
  endtask

  task automatic t_reset();
    for (int l = 0; l < NL; l++) begin skew[l] = l % 4; men[l] = 1'b1; end
    mode[0] = 0; mode[1] = 0;
    apply();
    adv(3);
    @(negedge clk);
    check("R1", "out_data in reset", (out_data == '0) ? 1 : 0, 1);
    check("R1", "out_mark in reset", out_mark, 0);
    check("R1", "bundle_aligned in reset", bundle_aligned, 0);
    check("R1", "skew_err in reset", skew_err, 0);
    rst_n = 1'b1;
    cyc++;
    apply();
    adv(20);
    // markers present but no load yet: all lanes bypass, no status
    adv_chk(20, "R1 R5", 8'h00);
  endtask

  task automatic t_x8();
    set_skews(0, 3, 1, 2);
    load(3, 3);
    adv(40);
    adv_chk(32, "R3 R4", 8'h11);
  endtask

  task automatic t_mixed();
    set_skews(2, 0, 3, 1);
    load(1, 2);
    adv(40);
    adv_chk(32, "R2 R11", 8'b0101_1111);
  endtask

  task automatic t_bypass();
    set_skews(1, 3, 0, 2);
    load(0, 3);
    adv(40);
    adv_chk(32, "R5 R11", 8'h10);
  endtask

  task automatic t_realign();
    set_skews(0, 1, 2, 3);
    load(3, 3);
    adv(40);
    adv_chk(16, "R3", 8'h11);
    goto_phase(8);
    set_skews(3, 3, 0, 1);
    adv(40);
    adv_chk(32, "R6", 8'h11);
  endtask

  task automatic t_missing();
    int errs = 0;
    goto_phase(8);
    men[3] = 1'b0;
    repeat (32) begin
      @(negedge clk);
      check_lanes("R7");
      if (skew_err) errs++;
      cyc++;
      apply();
    end
    check("R7", "skew_err pulses in two rounds", errs, 2);
    @(negedge clk);
    check("R8", "bundle_aligned after failed round", bundle_aligned, 8'h10);
    cyc++;
    apply();
    goto_phase(8);
    men[3] = 1'b1;
    adv(16);
    adv_chk(16, "R8", 8'h11);
  endtask

  task automatic t_midreset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc++;
    apply();
    @(negedge clk);
    check("R1", "bundle_aligned after mid reset", bundle_aligned, 0);
    check("R1", "out_data after mid reset", (out_data == '0) ? 1 : 0, 1);
    rst_n = 1'b1;
    mode[0] = 0; mode[1] = 0;
    cyc++;
    apply();
    adv(4);
    adv_chk(8, "R1", 8'h00);
  endtask

  initial begin
    t_reset();
    t_x8();
    t_mixed();
    t_bypass();
    t_realign();
    t_missing();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule